// File: doc/BRIEF.md
# Completion Ring Interrupt Coalescer

This block sits beside one receive DMA channel. It counts the completion entries that hardware has posted and software has not yet consumed. It raises a single-cycle event when that count first rises above a programmable threshold. It also raises an event when a prescaled countdown runs out while work is still pending. Software reports how many packets it has consumed, and the block subtracts that number from the count. Software also programs the threshold, the timeout, the timeout enable and the timer prescaler through a small configuration write port.

A control/status write port takes one-hot command bits. These bits clear individual sticky status flags and arm a one-shot mailbox request. When an event fires while the mailbox is armed, the block emits a mailbox-update request together with the event and disarms itself. Software must arm it again before it can get another request. The DMA transfers and the mailbox contents belong to other logic.

Top module: `rcr_coalescer`

## Requirements
- R1: The pending count rises by one for each cycle with `postValid` and falls by `updPkts` for each cycle with `updValid`. Both can happen in the same cycle. The count holds at its all-ones value instead of wrapping, and `pendCnt` shows the new value one cycle later.
- R2: An update larger than the pending count plus that cycle's post sets the pending count to zero. It also sets the sticky `updErr` flag, which is visible on the next cycle.
- R3: When the pending count first becomes larger than the threshold, `evtOut` pulses high for exactly one cycle, one cycle after the count changed. The pulse does not repeat while the count stays above the threshold. It can occur again only after the count has fallen back to the threshold or below.
- R4: The timeout runs only while the timeout is enabled and the pending count is nonzero. The timer ticks once every divider+1 cycles. After timeout-value ticks it fires an event, and `toStat` sets on the same cycle as `evtOut`. Any event, or a pending count of zero, reloads the timer and restarts the prescaler.
- R5: Configuration select 3 writes the timeout enable from data bit 0. Every accepted timeout write also turns the enable on, and reset leaves it on. While it is off, no timeout event fires.
- R6: Configuration select 0 writes the threshold. Only the values 1 to 511 are accepted. A 0, or any value of 512 or more, leaves the old threshold in place and sets the sticky `cfgErr`.
- R7: Configuration select 1 writes the timeout. Only the values 1 to 63 are accepted. A 0, or any value of 64 or more, is rejected and sets `cfgErr`.
- R8: Configuration select 2 writes the 16-bit prescaler divider, and every value is accepted.
- R9: Control bit 1 arms the mailbox. The first event that occurs while armed also pulses `mboxReq` for that cycle and disarms the mailbox. Later events give no request until the mailbox is armed again.
- R10: The control write bits act as follows:
  - bit 0 clears every sticky status flag;
  - bit 3 clears `toStat`;
  - bit 6 clears `shFullStat`;
  - bit 7 clears `ringFullStat`;
  - bit 9 clears `bufEmptyStat`.
  Each flag sets one cycle after its set input. When a set and a clear arrive in the same cycle, the set wins.
- R11: After reset the pending count and every output are zero. The threshold is 8, the timeout is 8, the divider is 0, the timeout is enabled and the mailbox is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| postValid | input | 1 | One completion entry posted this cycle |
| updValid | input | 1 | Software consumption report valid |
| updPkts | input | 16 | Number of packets consumed |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 threshold, 1 timeout, 2 divider, 3 timeout enable |
| cfgWrData | input | 16 | Configuration write data |
| csWrEn | input | 1 | Control/status write strobe |
| csWrData | input | 10 | One-hot control command bits |
| shFullSet | input | 1 | Shadow-full condition seen |
| ringFullSet | input | 1 | Completion-ring-full condition seen |
| bufEmptySet | input | 1 | Buffer-ring-empty condition seen |
| evtOut | output | 1 | Coalesced event pulse |
| mboxReq | output | 1 | Mailbox update request pulse |
| toStat | output | 1 | Sticky timeout status |
| shFullStat | output | 1 | Sticky shadow-full status |
| ringFullStat | output | 1 | Sticky ring-full status |
| bufEmptyStat | output | 1 | Sticky buffer-empty status |
| cfgErr | output | 1 | Sticky rejected-configuration flag |
| updErr | output | 1 | Sticky update-underflow flag |
| pendCnt | output | 16 | Pending completion count |

## Verification
A wrong pending count shows on `pendCnt` on the very next cycle. It also moves the threshold crossing, so `evtOut` comes early, comes late or goes missing. A timer or prescaler that is off by even one cycle shifts the timeout event and the `toStat` set. That shift shows up as soon as the first timeout expires, which can take up to timeout×(divider+1) cycles. A mailbox arm that is stuck or wrongly cleared shows as an extra or missing `mboxReq` at the next event. The bench's model predicts every output on every cycle, so any of these faults is caught on the first cycle it becomes visible.

// File: rtl/rcr_coal_pkg.sv
package rcr_coal_pkg;

  // strobes from the datapath to the control
  typedef struct packed {
    logic evt;     // any event this cycle
    logic toEvt;   // timeout expiry this cycle
    logic updOvf;  // software update underflowed the count
  } dpStb_t;

  typedef enum logic [1:0] {
    CFG_THR  = 2'd0,
    CFG_TMO  = 2'd1,
    CFG_DIV  = 2'd2,
    CFG_TOEN = 2'd3
  } cfgSel_e;

  localparam int CS_W        = 10;
  localparam int CS_CLR_ALL  = 0;
  localparam int CS_ARM      = 1;
  localparam int CS_CLR_TO   = 3;
  localparam int CS_CLR_SH   = 6;
  localparam int CS_CLR_RING = 7;
  localparam int CS_CLR_BUF  = 9;

endpackage

// File: rtl/rcr_coal_dp.sv
module rcr_coal_dp
  import rcr_coal_pkg::*;
#(
  parameter int PEND_W = 16,
  parameter int UPD_W  = 16,
  parameter int THR_W  = 9,
  parameter int TMO_W  = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic              updValid,
  input  logic [UPD_W-1:0]  updPkts,
  input  logic [THR_W-1:0]  thr,
  input  logic [TMO_W-1:0]  tmo,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              toEn,
  output logic [PEND_W-1:0] pendCnt,
  output dpStb_t            stb
);

  localparam int CMP_W = ((PEND_W > UPD_W) ? PEND_W : UPD_W) + 1;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pendQ;
  logic              aboveQ;
  logic [TMO_W-1:0]  tmrQ;
  logic [DIV_W-1:0]  preQ;

  logic              aboveNow, thrEvt, tick, toEvt, evt, reload;
  logic [PEND_W-1:0] sumSat, pendNext;
  logic              updOvf;

  // event detection from current state
  always_comb begin
    aboveNow = pendQ > PEND_W'(thr);
    thrEvt   = aboveNow && !aboveQ;
    tick     = (preQ == divVal);
    toEvt    = toEn && (pendQ != '0) && tick && (tmrQ == TMO_W'(1));
    evt      = thrEvt || toEvt;
    reload   = evt || (pendQ == '0) || !toEn;
  end

  // pending count arithmetic with saturation at both ends
  always_comb begin
    sumSat = pendQ;
    if (postValid && (pendQ != PEND_MAX)) sumSat = pendQ + PEND_W'(1);
    updOvf   = 1'b0;
    pendNext = sumSat;
    if (updValid) begin
      if (CMP_W'(updPkts) > CMP_W'(sumSat)) begin
        updOvf   = 1'b1;
        pendNext = '0;
      end else begin
        pendNext = sumSat - PEND_W'(updPkts);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      aboveQ <= 1'b0;
    end else begin
      pendQ  <= pendNext;
      aboveQ <= aboveNow;
    end
  end

  // prescaled countdown timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ <= TMO_W'(1);
      preQ <= '0;
    end else if (reload) begin
      tmrQ <= tmo;
      preQ <= '0;
    end else if (tick) begin
      tmrQ <= tmrQ - TMO_W'(1);
      preQ <= '0;
    end else begin
      preQ <= preQ + DIV_W'(1);
    end
  end

  assign pendCnt    = pendQ;
  assign stb.evt    = evt;
  assign stb.toEvt  = toEvt;
  assign stb.updOvf = updOvf;

  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    updOvf |=> (pendQ == '0)) else $error("pending not zero after underflow"); // R2
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!postValid && !updValid) |=> (pendQ == $past(pendQ))) else $error("pending moved without input"); // R1
  AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    tmrQ != '0) else $error("timer reached zero"); // R4
  AST_THR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    thrEvt |=> !thrEvt) else $error("threshold event repeated"); // R3

endmodule

// File: rtl/rcr_coal_ctrl.sv
module rcr_coal_ctrl
  import rcr_coal_pkg::*;
#(
  parameter int THR_W   = 9,
  parameter int TMO_W   = 6,
  parameter int DIV_W   = 16,
  parameter int CFG_W   = 16,
  parameter int THR_RST = 8,
  parameter int TMO_RST = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             csWrEn,
  input  logic [CS_W-1:0]  csWrData,
  input  logic             shFullSet,
  input  logic             ringFullSet,
  input  logic             bufEmptySet,
  input  dpStb_t           stb,
  output logic [THR_W-1:0] thr,
  output logic [TMO_W-1:0] tmo,
  output logic [DIV_W-1:0] divVal,
  output logic             toEn,
  output logic             evtOut,
  output logic             mboxReq,
  output logic             toStat,
  output logic             shFullStat,
  output logic             ringFullStat,
  output logic             bufEmptyStat,
  output logic             cfgErr,
  output logic             updErr
);

  localparam int THR_LIM = 2 ** THR_W;
  localparam int TMO_LIM = 2 ** TMO_W;

  logic [THR_W-1:0] thrQ;
  logic [TMO_W-1:0] tmoQ;
  logic [DIV_W-1:0] divQ;
  logic             toEnQ, armQ;
  logic             thrOk, tmoOk, cfgReject;
  logic             clrAll, clrTo, clrSh, clrRing, clrBuf, armWr;
  logic             unusedCs;

  always_comb begin
    thrOk     = (cfgWrData != '0) && (32'(cfgWrData) < THR_LIM);
    tmoOk     = (cfgWrData != '0) && (32'(cfgWrData) < TMO_LIM);
    cfgReject = cfgWrEn && (((cfgSel == CFG_THR) && !thrOk) ||
                            ((cfgSel == CFG_TMO) && !tmoOk));
    clrAll    = csWrEn && csWrData[CS_CLR_ALL];
    armWr     = csWrEn && csWrData[CS_ARM];
    clrTo     = clrAll || (csWrEn && csWrData[CS_CLR_TO]);
    clrSh     = clrAll || (csWrEn && csWrData[CS_CLR_SH]);
    clrRing   = clrAll || (csWrEn && csWrData[CS_CLR_RING]);
    clrBuf    = clrAll || (csWrEn && csWrData[CS_CLR_BUF]);
  end

  assign unusedCs = ^{csWrData[2], csWrData[5:4], csWrData[8]};

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ  <= THR_W'(THR_RST);
      tmoQ  <= TMO_W'(TMO_RST);
      divQ  <= '0;
      toEnQ <= 1'b1;
    end else if (cfgWrEn) begin
      case (cfgSel)
        CFG_THR:  if (thrOk) thrQ <= cfgWrData[THR_W-1:0];
        CFG_TMO:  if (tmoOk) begin
                    tmoQ  <= cfgWrData[TMO_W-1:0];
                    toEnQ <= 1'b1;
                  end
        CFG_DIV:  divQ  <= cfgWrData[DIV_W-1:0];
        default:  toEnQ <= cfgWrData[0];
      endcase
    end
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toStat       <= 1'b0;
      shFullStat   <= 1'b0;
      ringFullStat <= 1'b0;
      bufEmptyStat <= 1'b0;
      cfgErr       <= 1'b0;
      updErr       <= 1'b0;
    end else begin
      toStat       <= (toStat && !clrTo) || stb.toEvt;
      shFullStat   <= (shFullStat && !clrSh) || shFullSet;
      ringFullStat <= (ringFullStat && !clrRing) || ringFullSet;
      bufEmptyStat <= (bufEmptyStat && !clrBuf) || bufEmptySet;
      cfgErr       <= (cfgErr && !clrAll) || cfgReject;
      updErr       <= (updErr && !clrAll) || stb.updOvf;
    end
  end

  // one-shot mailbox arm and event outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ    <= 1'b0;
      evtOut  <= 1'b0;
      mboxReq <= 1'b0;
    end else begin
      evtOut  <= stb.evt;
      mboxReq <= stb.evt && armQ;
      if (armWr)        armQ <= 1'b1;
      else if (stb.evt) armQ <= 1'b0;
    end
  end

  assign thr    = thrQ;
  assign tmo    = tmoQ;
  assign divVal = divQ;
  assign toEn   = toEnQ;

  AST_MBOX_WITH_EVT: assert property (@(posedge clk) disable iff (!rstN)
    mboxReq |-> evtOut) else $error("mailbox request without event"); // R9
  AST_ARM_SPENT: assert property (@(posedge clk) disable iff (!rstN)
    (mboxReq && !$past(armWr)) |-> !armQ) else $error("arm survived request"); // R9
  AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    thrQ != '0) else $error("threshold zero"); // R6
  AST_TMO_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    tmoQ != '0) else $error("timeout zero"); // R7
  AST_TO_STAT_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.toEvt |=> toStat) else $error("timeout status not set"); // R4

endmodule

// File: rtl/rcr_coalescer.sv
module rcr_coalescer
  import rcr_coal_pkg::*;
#(
  parameter int PEND_W  = 16,
  parameter int UPD_W   = 16,
  parameter int THR_W   = 9,
  parameter int TMO_W   = 6,
  parameter int DIV_W   = 16,
  parameter int CFG_W   = 16,
  parameter int THR_RST = 8,
  parameter int TMO_RST = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic              updValid,
  input  logic [UPD_W-1:0]  updPkts,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              csWrEn,
  input  logic [9:0]        csWrData,
  input  logic              shFullSet,
  input  logic              ringFullSet,
  input  logic              bufEmptySet,
  output logic              evtOut,
  output logic              mboxReq,
  output logic              toStat,
  output logic              shFullStat,
  output logic              ringFullStat,
  output logic              bufEmptyStat,
  output logic              cfgErr,
  output logic              updErr,
  output logic [PEND_W-1:0] pendCnt
);

  dpStb_t           stb;
  logic [THR_W-1:0] thr;
  logic [TMO_W-1:0] tmo;
  logic [DIV_W-1:0] divVal;
  logic             toEn;

  rcr_coal_dp #(
    .PEND_W(PEND_W), .UPD_W(UPD_W), .THR_W(THR_W), .TMO_W(TMO_W), .DIV_W(DIV_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .postValid(postValid), .updValid(updValid),
    .updPkts(updPkts), .thr(thr), .tmo(tmo), .divVal(divVal), .toEn(toEn),
    .pendCnt(pendCnt), .stb(stb)
  );

  rcr_coal_ctrl #(
    .THR_W(THR_W), .TMO_W(TMO_W), .DIV_W(DIV_W), .CFG_W(CFG_W),
    .THR_RST(THR_RST), .TMO_RST(TMO_RST)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .csWrEn(csWrEn), .csWrData(csWrData),
    .shFullSet(shFullSet), .ringFullSet(ringFullSet), .bufEmptySet(bufEmptySet),
    .stb(stb), .thr(thr), .tmo(tmo), .divVal(divVal), .toEn(toEn),
    .evtOut(evtOut), .mboxReq(mboxReq), .toStat(toStat),
    .shFullStat(shFullStat), .ringFullStat(ringFullStat),
    .bufEmptyStat(bufEmptyStat), .cfgErr(cfgErr), .updErr(updErr)
  );

endmodule

// File: tb/test_rcr_coalescer.sv
`timescale 1ns/1ps
module test_rcr_coalescer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        postValid = 1'b0, updValid = 1'b0;
  logic [15:0] updPkts = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [15:0] cfgWrData = '0;
  logic        csWrEn = 1'b0;
  logic [9:0]  csWrData = '0;
  logic        shFullSet = 1'b0, ringFullSet = 1'b0, bufEmptySet = 1'b0;
  logic        evtOut, mboxReq, toStat, shFullStat, ringFullStat, bufEmptyStat, cfgErr, updErr;
  logic [15:0] pendCnt;

  int tests = 0, fails = 0;
  int evtCnt = 0, mboxCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rcr_coalescer i_rcr_coalescer (
    .clk(clk), .rstN(rstN), .postValid(postValid), .updValid(updValid),
    .updPkts(updPkts), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .csWrEn(csWrEn), .csWrData(csWrData), .shFullSet(shFullSet),
    .ringFullSet(ringFullSet), .bufEmptySet(bufEmptySet), .evtOut(evtOut),
    .mboxReq(mboxReq), .toStat(toStat), .shFullStat(shFullStat),
    .ringFullStat(ringFullStat), .bufEmptyStat(bufEmptyStat), .cfgErr(cfgErr),
    .updErr(updErr), .pendCnt(pendCnt)
  );

  // behavioural reference model
  int mPend, mThr, mTmo, mDiv, mTmr, mPre;
  bit mEn, mArm, mAbove;
  bit eEvt, eMbox, eTo, eSh, eRing, eBuf, eCfg, eUpd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend = 0; mThr = 8; mTmo = 8; mDiv = 0; mTmr = 1; mPre = 0;
      mEn = 1; mArm = 0; mAbove = 0;
      eEvt = 0; eMbox = 0; eTo = 0; eSh = 0; eRing = 0; eBuf = 0; eCfg = 0; eUpd = 0;
    end else begin
      bit above, thrE, tk, toE, ev, clrAll;
      int sum;
      above = mPend > mThr;
      thrE  = above && !mAbove;
      tk    = (mPre == mDiv);
      toE   = mEn && (mPend != 0) && tk && (mTmr == 1);
      ev    = thrE || toE;
      if (ev || mPend == 0 || !mEn) begin mTmr = mTmo; mPre = 0; end
      else if (tk) begin mPre = 0; mTmr = mTmr - 1; end
      else mPre = (mPre + 1) % 65536;
      mAbove = above;
      sum = mPend + ((postValid && mPend < 65535) ? 1 : 0);
      if (updValid) begin
        if (int'(updPkts) > sum) begin mPend = 0; eUpd = 1; end
        else mPend = sum - int'(updPkts);
      end else mPend = sum;
      clrAll = csWrEn && csWrData[0];
      eEvt  = ev;
      eMbox = ev && mArm;
      if (csWrEn && csWrData[1]) mArm = 1; else if (ev) mArm = 0;
      eTo   = (eTo && !(clrAll || (csWrEn && csWrData[3]))) || toE;
      eSh   = (eSh && !(clrAll || (csWrEn && csWrData[6]))) || shFullSet;
      eRing = (eRing && !(clrAll || (csWrEn && csWrData[7]))) || ringFullSet;
      eBuf  = (eBuf && !(clrAll || (csWrEn && csWrData[9]))) || bufEmptySet;
      if (clrAll) eCfg = 0;
      if (clrAll && !(updValid && int'(updPkts) > sum)) eUpd = 0;
      if (cfgWrEn) begin
        int d; d = int'(cfgWrData);
        case (cfgSel)
          2'd0: if (d >= 1 && d <= 511) mThr = d; else eCfg = 1;
          2'd1: if (d >= 1 && d <= 63) begin mTmo = d; mEn = 1; end else eCfg = 1;
          2'd2: mDiv = d;
          default: mEn = cfgWrData[0];
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model, then release strobes
  task automatic cyc();
    @(negedge clk);
    chk(pendCnt == 16'(mPend), "R1 pendCnt", pendCnt, mPend);
    chk(evtOut == eEvt, "R3 R4 evtOut", evtOut, eEvt);
    chk(mboxReq == eMbox, "R9 mboxReq", mboxReq, eMbox);
    chk(toStat == eTo, "R4 toStat", toStat, eTo);
    chk({shFullStat, ringFullStat, bufEmptyStat} == {eSh, eRing, eBuf}, "R10 status",
        {shFullStat, ringFullStat, bufEmptyStat}, {eSh, eRing, eBuf});
    chk(cfgErr == eCfg, "R6 R7 cfgErr", cfgErr, eCfg);
    chk(updErr == eUpd, "R2 updErr", updErr, eUpd);
    if (evtOut) evtCnt++;
    if (mboxReq) mboxCnt++;
    postValid = 0; updValid = 0; updPkts = 0; cfgWrEn = 0; csWrEn = 0; csWrData = 0;
    shFullSet = 0; ringFullSet = 0; bufEmptySet = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic cfgW(input logic [1:0] s, input int d);
    cfgWrEn = 1; cfgSel = s; cfgWrData = 16'(d); cyc();
  endtask

  task automatic csW(input logic [9:0] d);
    csWrEn = 1; csWrData = d; cyc();
  endtask

  task automatic post(input int n);
    for (int i = 0; i < n; i++) begin postValid = 1; cyc(); end
  endtask

  task automatic upd(input int n);
    updValid = 1; updPkts = 16'(n); cyc();
  endtask

  initial begin
    int e0, m0;
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk(pendCnt == 0 && !evtOut && !mboxReq && !toStat && !cfgErr && !updErr, "R11 reset outputs", pendCnt, 0);
    rstN = 1;
    idle(2);
    // R1 count with simultaneous post and update
    post(3);
    postValid = 1; updValid = 1; updPkts = 1; cyc();
    chk(pendCnt == 3, "R1 combined post/update", pendCnt, 3);
    upd(3);
    // configure thr 4, tmo 3, div 1
    cfgW(2'd0, 4); cfgW(2'd1, 3); cfgW(2'd2, 1);
    // R4 timeout fires with frames below threshold
    post(3); idle(12);
    chk(toStat == 1, "R4 timeout status", toStat, 1);
    upd(3); csW(10'h008);
    chk(toStat == 0, "R10 clear timeout code", toStat, 0);
    // R3 threshold crossing
    e0 = evtCnt; post(5); idle(1);
    chk(evtCnt - e0 >= 1, "R3 threshold event", evtCnt - e0, 1);
    upd(5); idle(2);
    // R9 one-shot mailbox
    m0 = mboxCnt; csW(10'h002);
    post(6); idle(2); upd(6); idle(2);
    post(6); idle(2); upd(6); idle(2);
    chk(mboxCnt - m0 == 1, "R9 single mailbox request", mboxCnt - m0, 1);
    // R2 underflow
    post(2);
    postValid = 1; updValid = 1; updPkts = 5; cyc();
    chk(updErr == 1 && pendCnt == 0, "R2 underflow", pendCnt, 0);
    csW(10'h001);
    chk(updErr == 0, "R10 clear all", updErr, 0);
    // R6 R7 illegal configuration
    cfgW(2'd0, 0);   chk(cfgErr == 1, "R6 threshold zero", cfgErr, 1); csW(10'h001);
    cfgW(2'd0, 512); chk(cfgErr == 1, "R6 threshold 512", cfgErr, 1); csW(10'h001);
    cfgW(2'd1, 0);   chk(cfgErr == 1, "R7 timeout zero", cfgErr, 1); csW(10'h001);
    cfgW(2'd1, 64);  chk(cfgErr == 1, "R7 timeout 64", cfgErr, 1); csW(10'h001);
    cfgW(2'd0, 511); chk(cfgErr == 0, "R6 threshold 511 legal", cfgErr, 0);
    cfgW(2'd0, 4);
    // R5 timeout disable and re-enable
    cfgW(2'd3, 0);
    e0 = evtCnt; post(1); idle(40);
    chk(evtCnt == e0, "R5 disabled no timeout", evtCnt - e0, 0);
    cfgW(2'd1, 2); idle(10);
    chk(evtCnt - e0 >= 1, "R5 re-enabled by timeout write", evtCnt - e0, 1);
    upd(1); csW(10'h001);
    // R8 large divider
    cfgW(2'd2, 20);
    e0 = evtCnt; post(1); idle(29);
    chk(evtCnt == e0, "R8 no early timeout", evtCnt - e0, 0);
    idle(20);
    chk(evtCnt - e0 >= 1, "R8 timeout with divider", evtCnt - e0, 1);
    upd(1); cfgW(2'd2, 1);
    // R10 status set and clear
    shFullSet = 1; ringFullSet = 1; bufEmptySet = 1; cyc();
    chk(shFullStat && ringFullStat && bufEmptyStat, "R10 status set", shFullStat, 1);
    csW(10'h040);
    chk(!shFullStat && ringFullStat, "R10 clear shadow-full only", shFullStat, 0);
    csW(10'h280);
    chk(!ringFullStat && !bufEmptyStat, "R10 clear ring and buffer", ringFullStat, 0);
    shFullSet = 1; csWrEn = 1; csWrData = 10'h040; cyc();
    chk(shFullStat == 1, "R10 set beats clear", shFullStat, 1);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      postValid = ($urandom % 3) == 0;
      if (($urandom % 9) == 0) begin updValid = 1; updPkts = 16'($urandom % (mPend + 2)); end
      if (($urandom % 23) == 0) begin
        csWrEn = 1;
        case ($urandom % 6)
          0: csWrData = 10'h001; 1: csWrData = 10'h002; 2: csWrData = 10'h008;
          3: csWrData = 10'h040; 4: csWrData = 10'h080; default: csWrData = 10'h200;
        endcase
      end
      if (($urandom % 37) == 0) begin
        cfgWrEn = 1; cfgSel = 2'($urandom % 4);
        case (cfgSel)
          2'd0: cfgWrData = 16'($urandom % 14);
          2'd1: cfgWrData = 16'($urandom % 9);
          2'd2: cfgWrData = 16'($urandom % 4);
          default: cfgWrData = 16'($urandom % 2);
        endcase
      end
      shFullSet = ($urandom % 50) == 0;
      ringFullSet = ($urandom % 50) == 0;
      bufEmptySet = ($urandom % 50) == 0;
      cyc();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule